// File: doc/BRIEF.md
# Way-Partitioned Victim Selector

This block chooses which way of one cache set is replaced when a requester misses. The caller presents the state bits of every way of the set: valid, dirty, locked and use. It also presents the class of the requester, which is one of several cores or one of two hardware-block groups. The block holds one programmable way mask per requester class. A 0 bit in a mask lets that class evict from the way, and a 1 bit forbids it. Masks limit only replacement. Reads and hit lookups never consult them and are outside this block.

One cycle after a request, the block returns the victim way and whether that victim holds dirty data that must be written back. It also returns a flag telling the caller to clear the set's use bits, a flag saying that no way could be chosen, and a grant for a request to lock the newly allocated line. It derives the set index from the request address, starting just above a 128-byte line offset. The tag store, the data store and the writeback path belong to the caller.

Top module: `way_victim_sel`

## Requirements
- R1: Each result appears on the outputs on the clock edge after the one that samples `req_valid_i` high, with `rsp_valid_o` high for exactly that cycle. `rsp_valid_o` is low in any cycle that follows a cycle without a request.
- R2: A way is eligible when its bit in the requester's mask is 0 and its line-lock bit is 0. Classes 0 to 3 are the cores, 4 is hardware group 0 and 5 is hardware group 1. Class codes 6 and 7 have no eligible way.
- R3: If any eligible way is invalid, the victim is the lowest-index eligible way whose valid bit is 0, even when a valid way with a clear use bit exists.
- R4: If every eligible way is valid, the victim is the lowest-index eligible way whose use bit is 0, and `rsp_use_clr_o` is 0. If every eligible way also has its use bit set, the victim is the lowest-index eligible way and `rsp_use_clr_o` is 1.
- R5: With no eligible way, `rsp_none_o` is 1 and `rsp_way_o`, `rsp_dirty_o`, `rsp_use_clr_o` and `rsp_lock_ok_o` are 0.
- R6: `rsp_dirty_o` is 1 exactly when the chosen way is both valid and dirty.
- R7: `rsp_lock_ok_o` is 1 only when the request asked for a lock and at least two ways were eligible. A lock is refused when the victim is the requester's last eligible way.
- R8: All masks reset to 0. A write whose mask has no 0 bit is dropped and the previous mask stays. Any other write replaces the selected class's mask and first affects requests one cycle after the write cycle. A request in the write cycle itself still sees the old mask.
- R9: `rsp_set_o` equals request address bits [16:7] for 1024 sets of 128-byte lines.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Mask write strobe |
| cfg_sel_i | input | 3 | Requester class whose mask is written |
| cfg_mask_i | input | 8 | New mask, 1 = way forbidden for eviction |
| req_valid_i | input | 1 | Miss request strobe |
| req_class_i | input | 3 | Requester class of the miss |
| req_lock_i | input | 1 | Request to lock the allocated line |
| req_addr_i | input | 32 | Physical address of the miss |
| tag_valid_i | input | 8 | Per-way valid bits of the set |
| tag_dirty_i | input | 8 | Per-way dirty bits |
| tag_lock_i | input | 8 | Per-way line-lock bits |
| tag_use_i | input | 8 | Per-way use bits |
| rsp_valid_o | output | 1 | Result valid |
| rsp_way_o | output | 3 | Victim way |
| rsp_dirty_o | output | 1 | Victim needs writeback |
| rsp_none_o | output | 1 | No eligible way |
| rsp_use_clr_o | output | 1 | Caller must clear the set's use bits |
| rsp_lock_ok_o | output | 1 | Lock of the allocated line granted |
| rsp_set_o | output | 10 | Set index of the request |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- A locked way that the mask allows: a selector that checks only the mask would evict that line.
- An invalid way that the mask forbids: a selector that ignores the mask would pick it instead of the first cold way.
- A requester left with a single eligible way: the lock must be refused there, while two eligible ways must still grant it.
- A rejected all-ones mask write: a bank that accepts it reports no victim afterwards.
- A request issued in the same cycle as a mask write: it must still see the old mask.
- A way forbidden for every class: it must never be returned.
- Out-of-range class codes: they must report no victim rather than alias onto a real class.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int unsigned LINE_OFF_DEF = 7;

  typedef enum logic [1:0] {
    PICK_NONE    = 2'd0,
    PICK_INVALID = 2'd1,
    PICK_COLD    = 2'd2,
    PICK_SWEEP   = 2'd3
  } pick_kind_e;
endpackage

// File: rtl/vsel_mask_bank.sv
module vsel_mask_bank #(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned NUM_REQ  = 6,
  parameter int unsigned CLS_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [CLS_W-1:0]    wsel_i,
  input  logic [NUM_WAYS-1:0] wdata_i,
  input  logic [CLS_W-1:0]    rsel_i,
  output logic [NUM_WAYS-1:0] rmask_o
);
  logic [NUM_WAYS-1:0] mask_q [NUM_REQ];
  logic                wr_ok;

  // a mask with no permitted way is refused
  assign wr_ok = we_i && (int'(wsel_i) < NUM_REQ) && (wdata_i != '1);

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mask_q[r] <= '0;
      else if (wr_ok && int'(wsel_i) == r)      mask_q[r] <= wdata_i;
    end
  end

  always_comb begin
    rmask_o = '1;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (int'(rsel_i) == r) rmask_o = mask_q[r];
    end
  end
endmodule

// File: rtl/vsel_lowest.sv
module vsel_lowest #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/vsel_pick.sv
module vsel_pick
  import vsel_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned WAY_W    = 3
) (
  input  logic [NUM_WAYS-1:0] forbid_i,
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [NUM_WAYS-1:0] lock_i,
  input  logic [NUM_WAYS-1:0] use_i,
  output pick_kind_e          kind_o,
  output logic [WAY_W-1:0]    way_o,
  output logic                multi_o
);
  localparam int unsigned CNT_W = $clog2(NUM_WAYS + 1);

  logic [NUM_WAYS-1:0] elig, inv_c, cold_c;
  logic                any_e, any_i, any_c;
  logic [WAY_W-1:0]    idx_e, idx_i, idx_c;
  logic [CNT_W-1:0]    n_elig;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign elig[w]   = !forbid_i[w] && !lock_i[w];
    assign inv_c[w]  = elig[w] && !valid_i[w];
    assign cold_c[w] = elig[w] && valid_i[w] && !use_i[w];
  end

  vsel_lowest #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_le (.vec_i(elig),   .any_o(any_e), .idx_o(idx_e));
  vsel_lowest #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_li (.vec_i(inv_c),  .any_o(any_i), .idx_o(idx_i));
  vsel_lowest #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_lc (.vec_i(cold_c), .any_o(any_c), .idx_o(idx_c));

  always_comb begin
    n_elig = '0;
    for (int w = 0; w < NUM_WAYS; w++) n_elig = n_elig + CNT_W'(elig[w]);
  end
  assign multi_o = n_elig >= CNT_W'(2);

  always_comb begin
    if (!any_e) begin
      kind_o = PICK_NONE;
      way_o  = '0;
    end else if (any_i) begin
      kind_o = PICK_INVALID;
      way_o  = idx_i;
    end else if (any_c) begin
      kind_o = PICK_COLD;
      way_o  = idx_c;
    end else begin
      kind_o = PICK_SWEEP;
      way_o  = idx_e;
    end
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
  import vsel_pkg::*;
#(
  parameter int unsigned NUM_WAYS      = 8,
  parameter int unsigned NUM_CORES     = 4,
  parameter int unsigned NUM_HW_GROUPS = 2,
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned LINE_OFF      = LINE_OFF_DEF,
  parameter int unsigned NUM_SETS      = 1024,
  localparam int unsigned NUM_REQ     = NUM_CORES + NUM_HW_GROUPS,
  localparam int unsigned CLS_W       = $clog2(NUM_REQ),
  localparam int unsigned WAY_W       = $clog2(NUM_WAYS),
  localparam int unsigned SET_W       = $clog2(NUM_SETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CLS_W-1:0]    cfg_sel_i,
  input  logic [NUM_WAYS-1:0] cfg_mask_i,
  input  logic                req_valid_i,
  input  logic [CLS_W-1:0]    req_class_i,
  input  logic                req_lock_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [NUM_WAYS-1:0] tag_valid_i,
  input  logic [NUM_WAYS-1:0] tag_dirty_i,
  input  logic [NUM_WAYS-1:0] tag_lock_i,
  input  logic [NUM_WAYS-1:0] tag_use_i,
  output logic                rsp_valid_o,
  output logic [WAY_W-1:0]    rsp_way_o,
  output logic                rsp_dirty_o,
  output logic                rsp_none_o,
  output logic                rsp_use_clr_o,
  output logic                rsp_lock_ok_o,
  output logic [SET_W-1:0]    rsp_set_o
);
  logic [NUM_WAYS-1:0] forbid;
  pick_kind_e          kind;
  logic [WAY_W-1:0]    way;
  logic                multi;
  logic                none_d, dirty_d;

  vsel_mask_bank #(.NUM_WAYS(NUM_WAYS), .NUM_REQ(NUM_REQ), .CLS_W(CLS_W)) u_masks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wsel_i (cfg_sel_i),
    .wdata_i(cfg_mask_i),
    .rsel_i (req_class_i),
    .rmask_o(forbid)
  );

  vsel_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_pick (
    .forbid_i(forbid),
    .valid_i (tag_valid_i),
    .lock_i  (tag_lock_i),
    .use_i   (tag_use_i),
    .kind_o  (kind),
    .way_o   (way),
    .multi_o (multi)
  );

  assign none_d  = (kind == PICK_NONE);
  assign dirty_d = !none_d && tag_valid_i[way] && tag_dirty_i[way];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_way_o     <= '0;
      rsp_dirty_o   <= 1'b0;
      rsp_none_o    <= 1'b0;
      rsp_use_clr_o <= 1'b0;
      rsp_lock_ok_o <= 1'b0;
      rsp_set_o     <= '0;
    end else if (req_valid_i) begin
      rsp_way_o     <= way;
      rsp_dirty_o   <= dirty_d;
      rsp_none_o    <= none_d;
      rsp_use_clr_o <= (kind == PICK_SWEEP);
      rsp_lock_ok_o <= req_lock_i && multi && !none_d;
      rsp_set_o     <= req_addr_i[LINE_OFF +: SET_W];
    end
  end
endmodule

// File: rtl/vsel_chk.sv
module vsel_chk #(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned CLS_W    = 3,
  parameter int unsigned WAY_W    = 3,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SET_W    = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_we_i,
  input logic [CLS_W-1:0]    cfg_sel_i,
  input logic [NUM_WAYS-1:0] cfg_mask_i,
  input logic                req_valid_i,
  input logic [CLS_W-1:0]    req_class_i,
  input logic                req_lock_i,
  input logic [ADDR_W-1:0]   req_addr_i,
  input logic [NUM_WAYS-1:0] tag_valid_i,
  input logic [NUM_WAYS-1:0] tag_dirty_i,
  input logic [NUM_WAYS-1:0] tag_lock_i,
  input logic [NUM_WAYS-1:0] tag_use_i,
  input logic                rsp_valid_o,
  input logic [WAY_W-1:0]    rsp_way_o,
  input logic                rsp_dirty_o,
  input logic                rsp_none_o,
  input logic                rsp_use_clr_o,
  input logic                rsp_lock_ok_o,
  input logic [SET_W-1:0]    rsp_set_o
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R1
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  // R5
  none_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_none_o) |-> (!rsp_dirty_o && !rsp_use_clr_o && !rsp_lock_ok_o && rsp_way_o == '0));

  // R2
  victim_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_none_o || (($past(tag_lock_i) & (NUM_WAYS'(1) << rsp_way_o)) == '0)));

  // R6
  dirty_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!rsp_dirty_o || (($past(tag_valid_i & tag_dirty_i) & (NUM_WAYS'(1) << rsp_way_o)) != '0)));

  // R7
  lock_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!rsp_lock_ok_o || $past(req_lock_i)));

  // R4
  use_clr_all_used_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!rsp_use_clr_o || (($past(tag_use_i & tag_valid_i) & (NUM_WAYS'(1) << rsp_way_o)) != '0)));
endmodule

bind way_victim_sel vsel_chk #(
  .NUM_WAYS(NUM_WAYS), .CLS_W(CLS_W), .WAY_W(WAY_W), .ADDR_W(ADDR_W), .SET_W(SET_W)
) u_chk (.*);

// File: tb/sim_way_victim_sel.sv
`timescale 1ns/1ps
module sim_way_victim_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_mask = '0;
  logic       req_valid = 1'b0;
  logic [2:0] req_class = '0;
  logic       req_lock = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0] t_valid = '0, t_dirty = '0, t_lock = '0, t_use = '0;
  logic       rsp_valid, rsp_dirty, rsp_none, rsp_use_clr, rsp_lock_ok;
  logic [2:0] rsp_way;
  logic [9:0] rsp_set;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  way_victim_sel u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_mask_i(cfg_mask),
    .req_valid_i(req_valid), .req_class_i(req_class), .req_lock_i(req_lock), .req_addr_i(req_addr),
    .tag_valid_i(t_valid), .tag_dirty_i(t_dirty), .tag_lock_i(t_lock), .tag_use_i(t_use),
    .rsp_valid_o(rsp_valid), .rsp_way_o(rsp_way), .rsp_dirty_o(rsp_dirty), .rsp_none_o(rsp_none),
    .rsp_use_clr_o(rsp_use_clr), .rsp_lock_ok_o(rsp_lock_ok), .rsp_set_o(rsp_set)
  );

  typedef struct packed {
    logic [2:0] cls;
    logic [7:0] v, d, l, u;
    logic       lk;
    logic [2:0] way;
    logic       dirty, none, uclr, grant;
  } vec_t;

  // masks during table: c0=00 c1=F0 c2=0F c3=FE hw0=3F hw1=00
  localparam logic [42:0] VECS [12] = '{
    {3'd0, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 sweep
    {3'd0, 8'hF7, 8'hFF, 8'h00, 8'hFF, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 R6
    {3'd1, 8'hFF, 8'h04, 8'h00, 8'h0B, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 R6
    {3'd2, 8'hFF, 8'h00, 8'h10, 8'h20, 1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 R7
    {3'd3, 8'hFF, 8'h01, 8'h00, 8'h00, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 last way
    {3'd3, 8'hFF, 8'h01, 8'h01, 8'h00, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5
    {3'd4, 8'hFF, 8'hC0, 8'h00, 8'hC0, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 R7
    {3'd5, 8'hFF, 8'h00, 8'h7F, 8'h80, 1'b1, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 R7
    {3'd6, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 bad class
    {3'd0, 8'hFF, 8'h80, 8'h00, 8'h7F, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 R6
    {3'd0, 8'hFB, 8'h00, 8'h04, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 locked invalid
    {3'd0, 8'hEF, 8'h00, 8'h00, 8'h00, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0}  // R3 beats cold
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_mask(input logic [2:0] sel, input logic [7:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic [2:0] c, input logic [7:0] v, d, l, u, input logic lk);
    req_class = c; t_valid = v; t_dirty = d; t_lock = l; t_use = u; req_lock = lk;
  endtask

  task automatic request(input logic [2:0] c, input logic [7:0] v, d, l, u, input logic lk);
    @(negedge clk);
    drive(c, v, d, l, u, lk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_rsp(input string tag, input logic [2:0] way, input logic dirty, none, uclr, grant);
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " way"}, 32'(rsp_way), 32'(way));
    check({tag, " dirty"}, 32'(rsp_dirty), 32'(dirty));
    check({tag, " none"}, 32'(rsp_none), 32'(none));
    check({tag, " use_clr"}, 32'(rsp_use_clr), 32'(uclr));
    check({tag, " lock_ok"}, 32'(rsp_lock_ok), 32'(grant));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 valid", 32'(rsp_valid), 0);
    check("R10 way", 32'(rsp_way), 0);
    check("R10 flags", {28'd0, rsp_dirty, rsp_none, rsp_use_clr, rsp_lock_ok}, 0);
    check("R10 set", 32'(rsp_set), 0);

    // R8 all-ones mask refused, old all-zero mask kept
    write_mask(3'd0, 8'hFF);
    request(3'd0, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0);
    check_rsp("R8 reject", 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    write_mask(3'd1, 8'hF0);
    write_mask(3'd2, 8'h0F);
    write_mask(3'd3, 8'hFE);
    write_mask(3'd4, 8'h3F);
    write_mask(3'd5, 8'h00);

    for (int i = 0; i < 12; i++) begin
      vec_t e;
      e = VECS[i];
      request(e.cls, e.v, e.d, e.l, e.u, e.lk);
      check_rsp($sformatf("R2-7 vec%0d", i), e.way, e.dirty, e.none, e.uclr, e.grant);
    end

    // R8 write and request in the same cycle: old mask applies
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_mask = 8'h01;
    drive(3'd0, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0);
    req_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check_rsp("R8 same cycle", 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    request(3'd0, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0);
    check_rsp("R8 new mask", 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2 way 0 forbidden for every class is never taken
    for (int c = 0; c < 6; c++) write_mask(3'(c), 8'h01);
    for (int c = 0; c < 6; c++) begin
      request(3'(c), 8'hFE, 8'h00, 8'h00, 8'h00, 1'b0);
      check_rsp($sformatf("R2 blocked cls%0d", c), 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    end

    // R9 set index
    @(negedge clk);
    req_addr = 32'h0001_2380;
    drive(3'd0, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 set", 32'(rsp_set), 32'h247);

    // R1 idle cycle drops valid
    @(negedge clk);
    check("R1 idle", 32'(rsp_valid), 0);

    // R1 back-to-back requests
    @(negedge clk);
    drive(3'd0, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0);
    req_valid = 1'b1;
    @(negedge clk);
    drive(3'd0, 8'hDF, 8'h00, 8'h00, 8'h00, 1'b0);
    check_rsp("R1 b2b first", 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R1 b2b second", 3'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 after b2b", 32'(rsp_valid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule